// File: doc/BRIEF.md
# Negative Exponential Interpolator

This block evaluates e^-x for an unsigned fixed-point argument x. It serves as the decay term of an annealing-style learning rule, where the argument is prepared elsewhere. The upper fractional bits of x, together with its integer bits, pick one of 64 stored samples of e^-x taken every 1/8 along the argument axis. The remaining low fractional bits weight a straight-line blend toward the next sample. Arguments of 8.0 or more give a result of exactly zero. The last sample is blended toward zero.

The blend product comes from one serial shift-and-add multiplier. That multiplier takes one multiplier bit per clock. A new argument is therefore taken only while the block is idle, and the result appears a fixed number of clocks after the argument is taken. The table itself is computed from the parameters when the design is elaborated, with integer arithmetic only.

Top module: `negexp_interp`

## Requirements
- R1: While reset is held, and after reset is released, `res_vld` is 0 and `res_val` is 0 until the first accepted argument completes.
- R2: An argument sampled with `arg_vld`=1 while idle produces `res_vld`=1 for exactly one cycle. This happens on the clock edge FRAC_W+1 edges after the sampling edge, and `res_vld` is 0 on every edge in between.
- R3: An argument of 0 gives 0x7FFF. The result is unsigned with 15 fractional bits, and 1.0 saturates to 0x7FFF.
- R4: When the low FRAC_W bits of `arg_x` are zero and x < 8, the result is within 1 LSB of round(32768·e^-x), clamped to 0x7FFF.
- R5: For every x < 8, |res_val/32768 − e^-x| < 2^-8. This includes the last 1/8 interval, where the blend target is zero.
- R6: When any bit of `arg_x` above bit FRAC_W+5 is set (x ≥ 8), the result is exactly 0.
- R7: `arg_vld` pulses that arrive while an argument is in progress are ignored. They produce no extra `res_vld`, and they do not change the pending result.
- R8: The result never increases as x increases over the whole argument range.
- R9: The result never exceeds 0x7FFF, and the blend subtraction never borrows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arg_vld | input | 1 | Argument strobe, taken only when idle |
| arg_x | input | INT_W+3+FRAC_W | Argument x: INT_W integer bits, 3 index fraction bits, FRAC_W blend bits |
| res_vld | output | 1 | One-cycle result strobe |
| res_val | output | 16 | e^-x, unsigned, 15 fractional bits |

## Verification
The bench builds the block with its defaults: FRAC_W=6 blend bits and INT_W=4 integer bits, a 13-bit argument. With these values the bench can sweep all 8192 arguments. The sweep reaches every table sample, every blend weight inside every interval, the last interval that blends toward zero, and the whole saturated region from 8.0 to just under 16.0. Each result is compared with a real-valued exponential. The sweep also tracks ordering between neighbouring arguments and the exact strobe timing.

// File: rtl/negexp_pkg.sv
package negexp_pkg;

  localparam int Q_W = 16;  // result width, 15 fractional bits

  // e^-(2^-s) in Q30 by a truncated power series, integer only
  function automatic longint step_ratio_q30(input int s);
    longint acc;
    longint term;
    acc  = longint'(1) <<< 40;
    term = longint'(1) <<< 40;
    for (int n = 1; n < 12; n++) begin
      term = -(term / (longint'(n) <<< s));
      acc  = acc + term;
    end
    return acc >>> 10;
  endfunction

  // sample k of round(32768*e^-(k*2^-s)), clamped to 0x7FFF; zero past n_ent
  function automatic logic [Q_W-1:0] sample_val(input int k, input int s, input int n_ent);
    longint v;
    longint r;
    longint q;
    if (k >= n_ent) return '0;
    r = step_ratio_q30(s);
    v = longint'(1) <<< 31;  // 32768 scaled by 2^16
    for (int j = 0; j < k; j++) v = (v * r) >>> 30;
    q = (v + (longint'(1) <<< 15)) >>> 16;
    if (q > 32767) q = 32767;
    return Q_W'(q);
  endfunction

endpackage

// File: rtl/negexp_rom.sv
module negexp_rom
  import negexp_pkg::*;
#(
  parameter int STEP_LOG2 = 3,
  parameter int IDX_W     = 6
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             sat,
  output logic [Q_W-1:0]   base,
  output logic [Q_W-1:0]   delta
);

  localparam int N_ENT = 1 << IDX_W;

  logic [Q_W-1:0]  tab [N_ENT+1];
  logic [IDX_W:0]  cur_i;
  logic [IDX_W:0]  nxt_i;

  for (genvar g = 0; g <= N_ENT; g++) begin : g_tab
    assign tab[g] = sample_val(g, STEP_LOG2, N_ENT);
  end

  assign cur_i = {1'b0, idx};
  assign nxt_i = cur_i + 1'b1;

  always_comb begin
    if (sat) begin
      base  = '0;
      delta = '0;
    end else begin
      base  = tab[cur_i];
      delta = tab[cur_i] - tab[nxt_i];
    end
  end

  // R8: neighbouring samples never rise
  always_comb begin
    a_r8_tab_order: assert (tab[cur_i] >= tab[nxt_i]);
  end

endmodule

// File: rtl/negexp_shiftadd_mul.sv
module negexp_shiftadd_mul #(
  parameter int A_W = 16,
  parameter int B_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [A_W-1:0]     mcand,
  input  logic [B_W-1:0]     mplier,
  output logic               busy,
  output logic               done,
  output logic [A_W+B_W-1:0] prod
);

  localparam int P_W   = A_W + B_W;
  localparam int CNT_W = (B_W > 1) ? $clog2(B_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(B_W - 1);

  logic [P_W-1:0]   mc_q,  mc_d;
  logic [B_W-1:0]   mp_q,  mp_d;
  logic [P_W-1:0]   acc_q, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;

  always_comb begin
    mc_d   = mc_q;
    mp_d   = mp_q;
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start && !busy_q) begin
      mc_d   = {{B_W{1'b0}}, mcand};
      mp_d   = mplier;
      acc_d  = '0;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (mp_q[0]) acc_d = acc_q + mc_q;
      mc_d  = mc_q << 1;
      mp_d  = mp_q >> 1;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q   <= '0;
      mp_q   <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      mc_q   <= mc_d;
      mp_q   <= mp_d;
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign prod = acc_q;

  // R2: completion only follows a running product
  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q));
  // R2: step counter stays within the multiplier width
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST));
  // R7: no restart while a product runs
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(mp_q) || (mp_q == ($past(mp_q) >> 1)));

endmodule

// File: rtl/negexp_interp.sv
module negexp_interp
  import negexp_pkg::*;
#(
  parameter int INT_W  = 4,
  parameter int FRAC_W = 6,
  localparam int STEP_LOG2 = 3,
  localparam int IDX_W     = 6,
  localparam int X_W       = INT_W + STEP_LOG2 + FRAC_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arg_vld,
  input  logic [X_W-1:0] arg_x,
  output logic           res_vld,
  output logic [Q_W-1:0] res_val
);

  localparam int P_W   = Q_W + FRAC_W;
  localparam int HI_W  = X_W - FRAC_W - IDX_W;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // argument split
  logic [IDX_W-1:0]  idx;
  logic [FRAC_W-1:0] frac;
  logic [HI_W-1:0]   hi;
  logic              sat;
  assign frac = arg_x[FRAC_W-1:0];
  assign idx  = arg_x[FRAC_W +: IDX_W];
  assign hi   = arg_x[X_W-1 -: HI_W];
  assign sat  = |hi;

  logic [Q_W-1:0] base, delta;
  negexp_rom #(.STEP_LOG2(STEP_LOG2), .IDX_W(IDX_W)) rom_i (
    .idx(idx), .sat(sat), .base(base), .delta(delta)
  );

  logic           run_q, run_d;
  logic [Q_W-1:0] a_q, a_d;
  logic           sat_q, sat_d;
  logic           vld_q, vld_d;
  logic [Q_W-1:0] val_q, val_d;
  logic           accept;
  logic           mul_busy, mul_done;
  logic [P_W-1:0] prod;

  assign accept = arg_vld && !run_q;

  negexp_shiftadd_mul #(.A_W(Q_W), .B_W(FRAC_W)) mul_i (
    .clk(clk), .rst_n(rst_i), .start(accept), .mcand(delta), .mplier(frac),
    .busy(mul_busy), .done(mul_done), .prod(prod)
  );

  // rounded blend and subtraction at full width
  logic [P_W:0] rsum;
  logic [P_W:0] dfull;
  assign rsum  = {1'b0, prod} + (P_W+1)'(1 << (FRAC_W - 1));
  assign dfull = ((P_W+1)'(a_q) << FRAC_W) - {rsum[P_W:FRAC_W], {FRAC_W{1'b0}}};

  always_comb begin
    run_d = run_q;
    a_d   = a_q;
    sat_d = sat_q;
    vld_d = 1'b0;
    val_d = val_q;
    if (accept) begin
      run_d = 1'b1;
      a_d   = base;
      sat_d = sat;
    end
    if (mul_done) begin
      run_d = 1'b0;
      vld_d = 1'b1;
      val_d = Q_W'(dfull >> FRAC_W);
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      run_q <= 1'b0;
      a_q   <= '0;
      sat_q <= 1'b0;
      vld_q <= 1'b0;
      val_q <= '0;
    end else begin
      run_q <= run_d;
      a_q   <= a_d;
      sat_q <= sat_d;
      vld_q <= vld_d;
      val_q <= val_d;
    end
  end

  assign res_vld = vld_q;
  assign res_val = val_q;

  // R9: the blend never borrows below zero
  always_comb begin
    if (mul_done) a_r9_no_borrow: assert (!dfull[P_W]);
  end

  // R2: result strobe lasts one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_i)
    vld_q |=> !vld_q);
  // R6: saturated arguments finish at exactly zero
  a_r6_sat_zero: assert property (@(posedge clk) disable iff (!rst_i)
    (vld_q && sat_q) |-> (val_q == '0));
  // R9: result stays at or below 0x7FFF
  a_r9_ceiling: assert property (@(posedge clk) disable iff (!rst_i)
    vld_q |-> !val_q[Q_W-1]);
  // R7: a strobe during a run leaves the captured sample alone
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_i)
    (run_q && arg_vld) |=> $stable(a_q));
  // R7: the multiplier is busy for the whole run
  a_r7_run_cover: assert property (@(posedge clk) disable iff (!rst_i)
    mul_busy |-> run_q);

endmodule

// File: tb/negexp_interp_tb_top.sv
module negexp_interp_tb_top;

  localparam int FW = 6;
  localparam int IW = 4;
  localparam int XW = IW + 3 + FW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arg_vld = 1'b0;
  logic [XW-1:0] arg_x = '0;
  logic          res_vld;
  logic [15:0]   res_val;

  int n_chk = 0;
  int n_fail = 0;
  bit done_f = 1'b0;

  always #5 clk = ~clk;

  negexp_interp #(.INT_W(IW), .FRAC_W(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .arg_vld(arg_vld), .arg_x(arg_x),
    .res_vld(res_vld), .res_val(res_val)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  function automatic real ref_exp(input int xv);
    return $exp(-(real'(xv) / real'(1 << (3 + FW))));
  endfunction

  // one argument; R2 timing checked inline
  task automatic apply(input int xv, output int got);
    @(negedge clk);
    arg_vld = 1'b1;
    arg_x   = XW'(xv);
    @(negedge clk);
    arg_vld = 1'b0;
    repeat (FW) @(negedge clk);
    check(res_vld == 1'b0, "R2 early", int'(res_vld), 0);
    @(negedge clk);
    check(res_vld == 1'b1, "R2 on time", int'(res_vld), 1);
    got = int'(res_val);
  endtask

  task automatic t_reset();
    // R1
    check(res_vld == 1'b0 && res_val == 16'h0, "R1 in reset", int'(res_val), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(res_vld == 1'b0 && res_val == 16'h0, "R1 after release", int'(res_val), 0);
  endtask

  task automatic t_sweep();
    int got;
    int prev;
    int e;
    real err;
    prev = 32767;
    for (int v = 0; v < (1 << XW); v++) begin
      apply(v, got);
      check(got <= 32767, "R9 ceiling", got, 32767);
      check(got <= prev, "R8 order", got, prev);
      prev = got;
      if (v == 0) begin
        check(got == 32767, "R3 one", got, 32767);
      end else if (v >= (8 << (3 + FW))) begin
        check(got == 0, "R6 saturate", got, 0);
      end else if ((v % (1 << FW)) == 0) begin
        e = int'($floor(32768.0 * ref_exp(v) + 0.5));
        if (e > 32767) e = 32767;
        check(got - e <= 1 && e - got <= 1, "R4 grid", got, e);
      end else begin
        err = real'(got) / 32768.0 - ref_exp(v);
        if (err < 0.0) err = -err;
        check(err < 1.0 / 256.0, "R5 blend", got, int'($floor(32768.0 * ref_exp(v) + 0.5)));
      end
    end
  endtask

  task automatic t_busy();
    int solo;
    int xa;
    int xb;
    xa = 5 * (1 << FW) + 37;
    xb = 900;
    apply(xa, solo);
    @(negedge clk);
    arg_vld = 1'b1;
    arg_x   = XW'(xa);
    @(negedge clk);
    arg_x = XW'(xb);        // held through every busy edge: R7
    repeat (FW) @(negedge clk);
    arg_vld = 1'b0;
    check(res_vld == 1'b0, "R7 no early", int'(res_vld), 0);
    @(negedge clk);
    check(res_vld == 1'b1 && int'(res_val) == solo, "R7 result kept", int'(res_val), solo);
    for (int k = 0; k < FW + 3; k++) begin
      @(negedge clk);
      check(res_vld == 1'b0, "R7 no extra", int'(res_vld), 0);
    end
  endtask

  initial begin
    t_reset();
    t_busy();
    t_sweep();
    done_f = 1'b1;
  end

  initial begin
    for (int c = 0; c < 190000 && !done_f; c++) @(posedge clk);
    if (!done_f) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule